// File: doc/BRIEF.md
# Duty-Cycled Receiver Polling Sequencer

This block sets the rhythm of a battery-powered radio receiver that must spend most of its time powered down. It loops through three phases: an idle phase with the signal chain switched off, a settling phase in which the chain is powered and allowed to stabilise, and a qualification phase in which an external detector decides whether a valid transmitter burst is present. A failed qualification sends the loop back to the idle phase. A passed one moves the receiver into a receive state that it holds.

The idle length is software-programmable through a write port. A 5-bit code is scaled by 1024 clocks, and an extension bit can multiply the result by eight. The all-ones code parks the receiver in idle until a different code is written. An external pin lets a host processor force the receiver on and later hand control back to the polling loop, so the host can run the polling itself.

Top module: `rx_poll_seq`

## Requirements
- R1: After reset the mode is idle (0), `chain_en` and `active` are low, and the stored code is 31, so the block stays idle until a write arrives.
- R2: With the extension bit at 0, a timed idle phase lasts exactly code × 1024 clock cycles.
- R3: With the extension bit at 1, a timed idle phase lasts exactly code × 8 × 1024 clock cycles.
- R4: The settling phase (mode 1) lasts exactly `STARTUP_CYC` cycles (default 16) and is followed by qualification (mode 2).
- R5: In qualification, a strobe on `chk_valid` with `chk_pass`=1 moves the block to receive (mode 3) on the next cycle. With `chk_pass`=0 it re-enters the idle sequence on the next cycle.
- R6: If no strobe arrives within `CHECK_TO` cycles (default 64) of qualification, that counts as a fail and the idle sequence is re-entered.
- R7: An idle sequence entered with code 0 skips idle and goes straight to settling.
- R8: An idle sequence entered with code 31 is permanent. A write of any code other than 31 moves the block to settling on the next cycle. A write of 31 (with either extension value) leaves it idle.
- R9: The idle length is captured when idle is entered. A write made during a timed idle phase only affects the next idle phase.
- R10: While `force_on` is high the mode becomes receive on the next cycle, from any state. When `force_on` falls, the idle sequence is entered on the next cycle.
- R11: Receive is held regardless of qualification strobes until `force_on` falls or reset is asserted.
- R12: The mode encoding is 0 idle, 1 settling, 2 qualification, 3 receive. `chain_en` is high in every mode except idle. `active` is high only in settling and qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the idle configuration |
| cfg_sleep_code | input | 5 | Idle length code (31 = permanent idle) |
| cfg_ext | input | 1 | Extension bit, multiplies the idle length by 8 |
| force_on | input | 1 | Host pin: high forces receive, falling edge returns to polling |
| chk_valid | input | 1 | Qualification result strobe |
| chk_pass | input | 1 | Qualification result, 1 = valid signal found |
| chain_en | output | 1 | Signal-chain enable |
| active | output | 1 | Polling-active indicator (settling or qualification) |
| mode | output | 2 | Current mode |

## Verification
A corrupted down-counter or a wrongly latched idle length shows up as an idle or settling phase that is too long or too short by a countable number of cycles. The bench measures every phase length on the `mode` port to the exact cycle. A mode register that takes an illegal path (idle straight to qualification, a receive state that drops on a strobe) shows up on the first cycle after the faulty transition. A lost permanent-idle flag shows up as an unprompted exit from idle within at most 31 × 8192 cycles; the bench observes that exit well before then because its permanent codes are tested after short waits.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

    localparam int SLP_CODE_W = 5;
    localparam logic [SLP_CODE_W-1:0] SLP_CODE_PERM = '1;

    typedef enum logic [1:0] {
        M_SLEEP = 2'd0,
        M_START = 2'd1,
        M_CHECK = 2'd2,
        M_RECV  = 2'd3
    } mode_t;

    typedef struct packed {
        logic [SLP_CODE_W-1:0] code;
        logic                  ext;
    } slp_cfg_t;

endpackage

// File: rtl/rx_poll_cfg.sv
module rx_poll_cfg
    import rx_poll_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SLP_CODE_W-1:0] wr_code,
    input  logic                  wr_ext,
    output slp_cfg_t              cfg
);

    slp_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.code = wr_code;
            cfg_d.ext  = wr_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code <= SLP_CODE_PERM;
            cfg_q.ext  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/rx_poll_len.sv
module rx_poll_len
    import rx_poll_pkg::*;
#(
    parameter int BASE_SHIFT = 10,
    parameter int EXT_SHIFT  = 3,
    localparam int LEN_W     = SLP_CODE_W + BASE_SHIFT + EXT_SHIFT
) (
    input  slp_cfg_t         cfg,
    output logic [LEN_W-1:0] len
);

    logic [LEN_W-1:0] base_len;

    assign base_len = LEN_W'(cfg.code) << BASE_SHIFT;

    generate
        if (EXT_SHIFT > 0) begin : g_ext
            assign len = cfg.ext ? (base_len << EXT_SHIFT) : base_len;
        end else begin : g_no_ext
            logic unused_ext;
            assign unused_ext = cfg.ext;
            assign len = base_len;
        end
    endgenerate

endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
    import rx_poll_pkg::*;
#(
    parameter int LEN_W       = 18,
    parameter int CNT_W       = 18,
    parameter int STARTUP_CYC = 16,
    parameter int CHECK_TO    = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slp_cfg_t              cfg,
    input  logic [LEN_W-1:0]      sleep_len,
    input  logic                  cfg_we,
    input  logic [SLP_CODE_W-1:0] wr_code,
    input  logic                  force_on,
    input  logic                  chk_valid,
    input  logic                  chk_pass,
    output logic                  chain_en,
    output logic                  active,
    output logic [1:0]            mode
);

    localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] CHECK_LOAD = CNT_W'(CHECK_TO - 1);

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] cnt;
        logic             perm;
        logic             force_prev;
    } seq_t;

    seq_t s_d, s_q;
    logic enter_sleep;

    always_comb begin
        s_d            = s_q;
        s_d.force_prev = force_on;
        enter_sleep    = 1'b0;

        if (force_on) begin
            s_d.mode = M_RECV;
            s_d.perm = 1'b0;
        end else if (s_q.force_prev) begin
            enter_sleep = 1'b1;
        end else begin
            unique case (s_q.mode)
                M_SLEEP: begin
                    if (s_q.perm) begin
                        if (cfg_we && (wr_code != SLP_CODE_PERM)) begin
                            s_d.mode = M_START;
                            s_d.perm = 1'b0;
                            s_d.cnt  = START_LOAD;
                        end
                    end else if (s_q.cnt == '0) begin
                        s_d.mode = M_START;
                        s_d.cnt  = START_LOAD;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                M_START: begin
                    if (s_q.cnt == '0) begin
                        s_d.mode = M_CHECK;
                        s_d.cnt  = CHECK_LOAD;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                M_CHECK: begin
                    if (chk_valid) begin
                        if (chk_pass) begin
                            s_d.mode = M_RECV;
                        end else begin
                            enter_sleep = 1'b1;
                        end
                    end else if (s_q.cnt == '0) begin
                        enter_sleep = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                default: begin
                    s_d.mode = M_RECV;
                end
            endcase
        end

        if (enter_sleep) begin
            if (cfg.code == SLP_CODE_PERM) begin
                s_d.mode = M_SLEEP;
                s_d.perm = 1'b1;
                s_d.cnt  = '0;
            end else if (sleep_len == '0) begin
                s_d.mode = M_START;
                s_d.perm = 1'b0;
                s_d.cnt  = START_LOAD;
            end else begin
                s_d.mode = M_SLEEP;
                s_d.perm = 1'b0;
                s_d.cnt  = CNT_W'(sleep_len) - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode       <= M_SLEEP;
            s_q.cnt        <= '0;
            s_q.perm       <= 1'b1;
            s_q.force_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode     = s_q.mode;
    assign chain_en = (s_q.mode != M_SLEEP);
    assign active   = (s_q.mode == M_START) || (s_q.mode == M_CHECK);

endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
    import rx_poll_pkg::*;
#(
    parameter int BASE_SHIFT  = 10,
    parameter int EXT_SHIFT   = 3,
    parameter int STARTUP_CYC = 16,
    parameter int CHECK_TO    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [4:0] cfg_sleep_code,
    input  logic       cfg_ext,
    input  logic       force_on,
    input  logic       chk_valid,
    input  logic       chk_pass,
    output logic       chain_en,
    output logic       active,
    output logic [1:0] mode
);

    localparam int LEN_W  = SLP_CODE_W + BASE_SHIFT + EXT_SHIFT;
    localparam int ST_W   = $clog2(STARTUP_CYC + 1);
    localparam int CK_W   = $clog2(CHECK_TO + 1);
    localparam int MAX_TW = (ST_W > CK_W) ? ST_W : CK_W;
    localparam int CNT_W  = (LEN_W > MAX_TW) ? LEN_W : MAX_TW;

    slp_cfg_t         cfg;
    logic [LEN_W-1:0] sleep_len;

    rx_poll_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_code (cfg_sleep_code),
        .wr_ext  (cfg_ext),
        .cfg     (cfg)
    );

    rx_poll_len #(
        .BASE_SHIFT (BASE_SHIFT),
        .EXT_SHIFT  (EXT_SHIFT)
    ) u_len (
        .cfg (cfg),
        .len (sleep_len)
    );

    rx_poll_fsm #(
        .LEN_W       (LEN_W),
        .CNT_W       (CNT_W),
        .STARTUP_CYC (STARTUP_CYC),
        .CHECK_TO    (CHECK_TO)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .sleep_len (sleep_len),
        .cfg_we    (cfg_we),
        .wr_code   (cfg_sleep_code),
        .force_on  (force_on),
        .chk_valid (chk_valid),
        .chk_pass  (chk_pass),
        .chain_en  (chain_en),
        .active    (active),
        .mode      (mode)
    );

endmodule

// File: rtl/rx_poll_seq_chk.sv
module rx_poll_seq_chk #(
    parameter int CHECK_TO = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       chain_en,
    input logic       active,
    input logic       force_on,
    input logic       chk_valid,
    input logic       chk_pass
);

    int unsigned check_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            check_run <= 0;
        end else if (mode == 2'd2) begin
            check_run <= check_run + 1;
        end else begin
            check_run <= 0;
        end
    end

    // R6: qualification never outlasts its timeout window
    a_r6_check_bound: assert property (@(posedge clk) disable iff (!rst_n)
        check_run <= CHECK_TO);

    // R5: a passing strobe leads to receive
    a_r5_pass_to_recv: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && chk_valid && chk_pass) |=> (mode == 2'd3));

    // R5: a failing strobe leaves qualification for idle or settling
    a_r5_fail_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && chk_valid && !chk_pass && !force_on) |=> (mode == 2'd0 || mode == 2'd1));

    // R10: the host pin forces receive
    a_r10_force_recv: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> (mode == 2'd3));

    // R11: receive persists while the host pin stays low
    a_r11_recv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !force_on && $past(!force_on)) |=> (mode == 2'd3));

    // R12: the polling indicator implies an enabled chain
    a_r12_active_chain: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> chain_en);

    // R4: settling never jumps back into idle without the host pin
    a_r4_start_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (mode != 2'd0));

    // R1: idle exits only to settling or receive
    a_r1_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (mode != 2'd2));

endmodule

bind rx_poll_seq rx_poll_seq_chk #(.CHECK_TO(CHECK_TO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .chain_en  (chain_en),
    .active    (active),
    .force_on  (force_on),
    .chk_valid (chk_valid),
    .chk_pass  (chk_pass)
);

// File: tb/sim_rx_poll_seq.sv
`timescale 1ns/1ps
module sim_rx_poll_seq;

    localparam int STARTUP_CYC = 16;
    localparam int CHECK_TO    = 64;
    localparam int NVEC        = 6;
    // {code, ext, expected idle cycles}
    localparam logic [21:0] VEC [NVEC] = '{
        {5'd1, 1'b0, 16'd1024},
        {5'd2, 1'b0, 16'd2048},
        {5'd1, 1'b1, 16'd8192},
        {5'd0, 1'b0, 16'd0},
        {5'd3, 1'b0, 16'd3072},
        {5'd0, 1'b1, 16'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_sleep_code = '0;
    logic       cfg_ext = 1'b0;
    logic       force_on = 1'b0;
    logic       chk_valid = 1'b0;
    logic       chk_pass = 1'b0;
    logic       chain_en, active;
    logic [1:0] mode;

    int n_checks = 0;
    int n_fails  = 0;
    int n;

    always #2.5 clk = ~clk;

    rx_poll_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_sleep_code (cfg_sleep_code),
        .cfg_ext        (cfg_ext),
        .force_on       (force_on),
        .chk_valid      (chk_valid),
        .chk_pass       (chk_pass),
        .chain_en       (chain_en),
        .active         (active),
        .mode           (mode)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic count_mode(input logic [1:0] m, output int cnt);
        cnt = 0;
        while (mode == m && cnt < 20000) begin
            cnt++;
            tick();
        end
    endtask

    task automatic write_cfg(input logic [4:0] code, input logic ext);
        cfg_we = 1'b1;
        cfg_sleep_code = code;
        cfg_ext = ext;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input logic pass);
        chk_valid = 1'b1;
        chk_pass = pass;
        tick();
        chk_valid = 1'b0;
        chk_pass = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 / R12 reset state
        check_eq("R1", "mode in reset", mode, 0);
        check_eq("R12", "chain_en in reset", chain_en, 0);
        rst_n = 1'b1;
        repeat (200) tick();
        check_eq("R1", "idle held after reset", mode, 0);
        check_eq("R1", "active after reset", active, 0);

        // R8: leaving permanent idle
        write_cfg(5'd1, 1'b0);
        check_eq("R8", "settling after write", mode, 1);
        check_eq("R12", "chain_en settling", chain_en, 1);
        check_eq("R12", "active settling", active, 1);
        count_mode(2'd1, n);
        check_eq("R4", "settling length", n, STARTUP_CYC);
        check_eq("R4", "qualification follows", mode, 2);

        // R2 / R3 / R7 vector walk
        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VEC[i][21:17], VEC[i][16]);
            strobe(1'b0);
            count_mode(2'd0, n);
            check_eq(VEC[i][16] ? "R3" : (VEC[i][21:17] == 0 ? "R7" : "R2"),
                     "idle length", n, int'(VEC[i][15:0]));
            check_eq("R5", "settling after idle", mode, 1);
            count_mode(2'd1, n);
            check_eq("R4", "settling length", n, STARTUP_CYC);
        end

        // R6 timeout with code 0 (R7 skip)
        count_mode(2'd2, n);
        check_eq("R6", "qualification timeout", n, CHECK_TO);
        check_eq("R7", "timeout skips idle", mode, 1);
        count_mode(2'd1, n);

        // R9 write during idle
        write_cfg(5'd2, 1'b0);
        strobe(1'b0);
        n = 0;
        while (mode == 2'd0 && n < 20000) begin
            if (n == 100) begin
                cfg_we = 1'b1;
                cfg_sleep_code = 5'd1;
                cfg_ext = 1'b0;
            end else begin
                cfg_we = 1'b0;
            end
            n++;
            tick();
        end
        cfg_we = 1'b0;
        check_eq("R9", "current idle unaffected", n, 2048);
        count_mode(2'd1, n);
        strobe(1'b0);
        count_mode(2'd0, n);
        check_eq("R9", "next idle uses new code", n, 1024);
        count_mode(2'd1, n);

        // R5 pass, R11 hold
        strobe(1'b1);
        check_eq("R5", "receive after pass", mode, 3);
        check_eq("R12", "active in receive", active, 0);
        check_eq("R12", "chain_en in receive", chain_en, 1);
        for (int k = 0; k < 300; k++) begin
            chk_valid = k[0];
            chk_pass = 1'b0;
            tick();
        end
        chk_valid = 1'b0;
        check_eq("R11", "receive held", mode, 3);

        // R10 host pin
        force_on = 1'b1;
        tick();
        check_eq("R10", "forced receive", mode, 3);
        force_on = 1'b0;
        tick();
        check_eq("R10", "idle after release", mode, 0);
        repeat (10) tick();
        force_on = 1'b1;
        tick();
        check_eq("R10", "force from idle", mode, 3);
        force_on = 1'b0;
        tick();
        count_mode(2'd0, n);
        check_eq("R10", "fresh idle after release", n, 1024);
        count_mode(2'd1, n);

        // R8 permanent idle
        write_cfg(5'd31, 1'b0);
        strobe(1'b0);
        repeat (500) tick();
        check_eq("R8", "permanent idle", mode, 0);
        write_cfg(5'd31, 1'b1);
        check_eq("R8", "rewrite of 31 ignored", mode, 0);
        write_cfg(5'd2, 1'b0);
        check_eq("R8", "exit permanent idle", mode, 1);
        count_mode(2'd1, n);

        // R1 reset from receive
        strobe(1'b1);
        check_eq("R5", "receive again", mode, 3);
        rst_n = 1'b0;
        tick();
        check_eq("R1", "reset mode", mode, 0);
        check_eq("R1", "reset chain_en", chain_en, 0);
        rst_n = 1'b1;
        repeat (50) tick();
        check_eq("R1", "permanent idle after reset", mode, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule